// File: doc/BRIEF.md
# Coalesced Translation Response Distributor

This block sits below an address-translation merging stage and above the translation lookaside buffer. The merging stage sends one translation request per group of requests that share a virtual page. When it does so, it records the group in a small outstanding table inside this block. The record holds the page key, the member count, and each member's full virtual address and requester ID. The issue logic chooses the table slot and watches the per-slot busy vector, so it knows when a page is free to be issued again.

When the buffer returns a translation, the block finds the group by the virtual page of the returned address. It then sends one response per member, one member per cycle, over a valid/ready handshake. Only the leading member was actually translated. That member gets the returned physical address as it is. Every later member gets a physical address built from the returned physical page and its own offset within that page. The page size comes from the returned entry, so more than one page size is handled. The attribute fields are copied to every member: the uncacheable flag, the hit level and the entry's base addresses. While a group is being sent, the block refuses further translations. When the last member is accepted, the slot is released and reads as free on the next cycle. A returned translation that matches no busy slot is dropped and flagged.

Top module: `xlat_rsp_fanout`

## Requirements
- R1: An install (`ins_valid`) is taken only when the named slot is free and `ins_count` is between 1 and MAXMEM. The slot's `slot_busy` bit then rises on the next cycle. An install naming a busy slot, or carrying an out-of-range count, leaves the table unchanged.
- R2: A returned translation is matched by comparing `tr_vaddr[ADDR_W-1:PG_SHIFT]` with the keys of the busy slots. When several busy slots hold the same key, the lowest-numbered one is served.
- R3: `tr_ready` is high while no group is being sent. It falls in the cycle after a matching translation is accepted and rises again in the cycle after the last member's handshake.
- R4: A matched group produces exactly `count` responses, for members 0 to count-1 in order. The first response is valid in the cycle after acceptance, and each handshake moves to the next member. The outputs hold steady while `rsp_ready` is low.
- R5: Member 0 carries `tr_paddr` unchanged.
- R6: Each later member carries (`tr_paddr` with its low S bits cleared) ORed with (the member's virtual address with all but its low S bits cleared), where S is `tr_pg_shift`.
- R7: Every member response carries the accepted translation's uncacheable flag, hit level, entry virtual base and entry physical base.
- R8: Each response's `rsp_id` is the requester ID recorded for that member.
- R9: The served slot's `slot_busy` bit falls in the cycle after the last member's handshake.
- R10: An accepted translation that matches no busy slot raises `tr_err` for exactly the next cycle. It produces no response and leaves the table unchanged.
- R11: After reset, `tr_ready` is high, `rsp_valid` and `tr_err` are low, and all slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Record a new group in the table |
| ins_slot | input | SLOT_W | Slot to fill |
| ins_vpage | input | KEY_W | Virtual page key of the group |
| ins_count | input | CNT_W | Number of members |
| ins_vaddrs | input | MAXMEM*ADDR_W | Member virtual addresses, member m at bits m*ADDR_W upward |
| ins_ids | input | MAXMEM*ID_W | Member requester IDs, member m at bits m*ID_W upward |
| slot_busy | output | NSLOT | Per-slot occupancy |
| tr_valid | input | 1 | Returned translation present |
| tr_ready | output | 1 | Block can take a translation |
| tr_vaddr | input | ADDR_W | Virtual address of the translated leading member |
| tr_paddr | input | ADDR_W | Physical address returned for it |
| tr_pg_shift | input | SH_W | log2 of the page size in the returned entry |
| tr_uncache | input | 1 | Returned entry is uncacheable |
| tr_hit_lvl | input | LVL_W | Level at which the translation hit |
| tr_ent_vbase | input | ADDR_W | Entry virtual base |
| tr_ent_pbase | input | ADDR_W | Entry physical base |
| tr_err | output | 1 | Unmatched translation was dropped |
| rsp_valid | output | 1 | Member response present |
| rsp_ready | input | 1 | Requester side accepts the response |
| rsp_id | output | ID_W | Requester ID of the member |
| rsp_paddr | output | ADDR_W | Member physical address |
| rsp_uncache | output | 1 | Uncacheable flag |
| rsp_hit_lvl | output | LVL_W | Hit level |
| rsp_ent_vbase | output | ADDR_W | Entry virtual base |
| rsp_ent_pbase | output | ADDR_W | Entry physical base |

## Verification
The results have these due times, all counted from the clock edge named:
- The first response, the fall of `tr_ready` and a miss's `tr_err` pulse are due one cycle after the edge that accepts the translation.
- Each later member is due one cycle after the previous handshake edge.
- The slot release and the return of `tr_ready` are due one cycle after the last handshake.
- An install shows on `slot_busy` one cycle after its edge.

The bench keeps a behavioural model that it advances on every rising edge from the same inputs. On every falling edge it compares all outputs against that model, so a result that arrives one cycle early or late is reported in the cycle it goes wrong.

// File: rtl/xrf_pkg.sv
package xrf_pkg;

   typedef enum logic {
      XS_IDLE = 1'b0,
      XS_SEND = 1'b1
   } xs_state_e;

   // width able to hold the values 0..n
   function automatic int unsigned cnt_width(int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/xrf_slot_table.sv
module xrf_slot_table #(
   parameter int unsigned NSLOT  = 4,
   parameter int unsigned MAXMEM = 4,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned KEY_W  = 20,
   parameter int unsigned ID_W   = 3,
   parameter int unsigned SLOT_W = 2,
   parameter int unsigned MEM_W  = 2,
   parameter int unsigned CNT_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ins_valid,
   input  logic [SLOT_W-1:0]        ins_slot,
   input  logic [KEY_W-1:0]         ins_key,
   input  logic [CNT_W-1:0]         ins_cnt,
   input  logic [MAXMEM*ADDR_W-1:0] ins_va,
   input  logic [MAXMEM*ID_W-1:0]   ins_id,
   input  logic [KEY_W-1:0]         look_key,
   output logic                     look_hit,
   output logic [SLOT_W-1:0]        look_slot,
   input  logic                     ret_en,
   input  logic [SLOT_W-1:0]        ret_slot,
   input  logic [SLOT_W-1:0]        rd_slot,
   input  logic [MEM_W-1:0]         rd_mem,
   output logic [ADDR_W-1:0]        rd_va,
   output logic [ID_W-1:0]          rd_id,
   output logic [CNT_W-1:0]         rd_cnt,
   output logic [NSLOT-1:0]         busy
);

   logic [NSLOT-1:0]  vld_q;
   logic [KEY_W-1:0]  key_q [NSLOT];
   logic [CNT_W-1:0]  cnt_q [NSLOT];
   logic [ADDR_W-1:0] va_q  [NSLOT][MAXMEM];
   logic [ID_W-1:0]   id_q  [NSLOT][MAXMEM];
   logic [NSLOT-1:0]  match;
   logic              cnt_ok;
   logic              ins_take;

   assign cnt_ok   = (ins_cnt != '0) && (ins_cnt <= CNT_W'(MAXMEM));
   assign ins_take = ins_valid && cnt_ok && !vld_q[ins_slot];

   // occupancy: a retiring slot is always busy, so it never collides with a take
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         for (int s = 0; s < NSLOT; s++) begin
            if (ret_en && (ret_slot == SLOT_W'(s)))
               vld_q[s] <= 1'b0;
            if (ins_take && (ins_slot == SLOT_W'(s)))
               vld_q[s] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (ins_take) begin
         key_q[ins_slot] <= ins_key;
         cnt_q[ins_slot] <= ins_cnt;
         for (int m = 0; m < MAXMEM; m++) begin
            va_q[ins_slot][m] <= ins_va[m*ADDR_W +: ADDR_W];
            id_q[ins_slot][m] <= ins_id[m*ID_W +: ID_W];
         end
      end
   end

   // page-key comparators, one per slot
   for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (key_q[g] == look_key);
   end

   // lowest-numbered matching slot wins
   always_comb begin
      look_hit  = |match;
      look_slot = '0;
      for (int s = NSLOT - 1; s >= 0; s--) begin
         if (match[s])
            look_slot = SLOT_W'(s);
      end
   end

   assign rd_va  = va_q[rd_slot][rd_mem];
   assign rd_id  = id_q[rd_slot][rd_mem];
   assign rd_cnt = cnt_q[rd_slot];
   assign busy   = vld_q;

   AST_INSTALL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !busy[ins_slot] && (ins_cnt != '0) && (ins_cnt <= CNT_W'(MAXMEM)))
      |=> busy[$past(ins_slot)]); // R1

   AST_BUSY_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && busy[ins_slot] && !(ret_en && (ret_slot == ins_slot)))
      |=> (busy[$past(ins_slot)] && (key_q[$past(ins_slot)] == $past(key_q[ins_slot]))
           && (cnt_q[$past(ins_slot)] == $past(cnt_q[ins_slot])))); // R1

   AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      ret_en |=> !busy[$past(ret_slot)]); // R9

endmodule

// File: rtl/xrf_pa_merge.sv
module xrf_pa_merge #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SH_W   = 5
) (
   input  logic [ADDR_W-1:0] base_pa,
   input  logic [SH_W-1:0]   shift,
   input  logic [ADDR_W-1:0] member_va,
   input  logic              first,
   output logic [ADDR_W-1:0] pa
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] off_mask;

   assign off_mask = (ONE << shift) - ONE;

   always_comb begin
      if (first)
         pa = base_pa;
      else
         pa = (base_pa & ~off_mask) | (member_va & off_mask);
   end

endmodule

// File: rtl/xrf_seq.sv
module xrf_seq
   import xrf_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SH_W   = 5,
   parameter int unsigned LVL_W  = 2,
   parameter int unsigned SLOT_W = 2,
   parameter int unsigned MEM_W  = 2,
   parameter int unsigned CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tr_valid,
   output logic              tr_ready,
   input  logic [ADDR_W-1:0] tr_paddr,
   input  logic [SH_W-1:0]   tr_pg_shift,
   input  logic              tr_uncache,
   input  logic [LVL_W-1:0]  tr_hit_lvl,
   input  logic [ADDR_W-1:0] tr_ent_vbase,
   input  logic [ADDR_W-1:0] tr_ent_pbase,
   input  logic              look_hit,
   input  logic [SLOT_W-1:0] look_slot,
   input  logic [CNT_W-1:0]  rd_cnt,
   input  logic              rsp_ready,
   output logic              rsp_valid,
   output logic [SLOT_W-1:0] cur_slot,
   output logic [MEM_W-1:0]  cur_mem,
   output logic              first,
   output logic [ADDR_W-1:0] h_paddr,
   output logic [SH_W-1:0]   h_shift,
   output logic              h_unc,
   output logic [LVL_W-1:0]  h_lvl,
   output logic [ADDR_W-1:0] h_vbase,
   output logic [ADDR_W-1:0] h_pbase,
   output logic              ret_en,
   output logic [SLOT_W-1:0] ret_slot,
   output logic              tr_err
);

   xs_state_e         state_q;
   logic [SLOT_W-1:0] slot_q;
   logic [MEM_W-1:0]  idx_q;
   logic              err_q;
   logic              last;

   assign last = ((CNT_W'(idx_q) + CNT_W'(1)) == rd_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         slot_q  <= '0;
         idx_q   <= '0;
         err_q   <= 1'b0;
         h_paddr <= '0;
         h_shift <= '0;
         h_unc   <= 1'b0;
         h_lvl   <= '0;
         h_vbase <= '0;
         h_pbase <= '0;
      end else begin
         err_q <= 1'b0;
         case (state_q)
            XS_IDLE: begin
               if (tr_valid) begin
                  if (look_hit) begin
                     state_q <= XS_SEND;
                     slot_q  <= look_slot;
                     idx_q   <= '0;
                     h_paddr <= tr_paddr;
                     h_shift <= tr_pg_shift;
                     h_unc   <= tr_uncache;
                     h_lvl   <= tr_hit_lvl;
                     h_vbase <= tr_ent_vbase;
                     h_pbase <= tr_ent_pbase;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            XS_SEND: begin
               if (rsp_ready) begin
                  if (last)
                     state_q <= XS_IDLE;
                  else
                     idx_q <= idx_q + MEM_W'(1);
               end
            end
            default: state_q <= XS_IDLE;
         endcase
      end
   end

   assign tr_ready  = (state_q == XS_IDLE);
   assign rsp_valid = (state_q == XS_SEND);
   assign cur_slot  = slot_q;
   assign cur_mem   = idx_q;
   assign first     = (idx_q == '0);
   assign ret_en    = (state_q == XS_SEND) && rsp_ready && last;
   assign ret_slot  = slot_q;
   assign tr_err    = err_q;

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(cur_mem) && $stable(cur_slot))); // R4

   AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      ret_en |=> tr_ready); // R3

   AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      tr_err |-> (!rsp_valid && tr_ready)); // R10

endmodule

// File: rtl/xlat_rsp_fanout.sv
module xlat_rsp_fanout #(
   parameter int unsigned NSLOT    = 4,
   parameter int unsigned MAXMEM   = 4,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned PG_SHIFT = 12,
   parameter int unsigned ID_W     = 3,
   parameter int unsigned LVL_W    = 2,
   localparam int unsigned SLOT_W  = $clog2(NSLOT),
   localparam int unsigned MEM_W   = $clog2(MAXMEM),
   localparam int unsigned CNT_W   = xrf_pkg::cnt_width(MAXMEM),
   localparam int unsigned SH_W    = $clog2(ADDR_W),
   localparam int unsigned KEY_W   = ADDR_W - PG_SHIFT
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ins_valid,
   input  logic [SLOT_W-1:0]        ins_slot,
   input  logic [KEY_W-1:0]         ins_vpage,
   input  logic [CNT_W-1:0]         ins_count,
   input  logic [MAXMEM*ADDR_W-1:0] ins_vaddrs,
   input  logic [MAXMEM*ID_W-1:0]   ins_ids,
   output logic [NSLOT-1:0]         slot_busy,
   input  logic                     tr_valid,
   output logic                     tr_ready,
   input  logic [ADDR_W-1:0]        tr_vaddr,
   input  logic [ADDR_W-1:0]        tr_paddr,
   input  logic [SH_W-1:0]          tr_pg_shift,
   input  logic                     tr_uncache,
   input  logic [LVL_W-1:0]         tr_hit_lvl,
   input  logic [ADDR_W-1:0]        tr_ent_vbase,
   input  logic [ADDR_W-1:0]        tr_ent_pbase,
   output logic                     tr_err,
   output logic                     rsp_valid,
   input  logic                     rsp_ready,
   output logic [ID_W-1:0]          rsp_id,
   output logic [ADDR_W-1:0]        rsp_paddr,
   output logic                     rsp_uncache,
   output logic [LVL_W-1:0]         rsp_hit_lvl,
   output logic [ADDR_W-1:0]        rsp_ent_vbase,
   output logic [ADDR_W-1:0]        rsp_ent_pbase
);

   if (NSLOT < 2 || (1 << SLOT_W) != NSLOT) begin : g_bad_nslot
      $error("NSLOT must be a power of two of at least 2");
   end
   if (MAXMEM < 2 || (1 << MEM_W) != MAXMEM) begin : g_bad_maxmem
      $error("MAXMEM must be a power of two of at least 2");
   end
   if (PG_SHIFT < 1 || PG_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("PG_SHIFT must lie inside the address");
   end

   logic              look_hit;
   logic [SLOT_W-1:0] look_slot;
   logic              ret_en;
   logic [SLOT_W-1:0] ret_slot;
   logic [SLOT_W-1:0] cur_slot;
   logic [MEM_W-1:0]  cur_mem;
   logic [ADDR_W-1:0] rd_va;
   logic [CNT_W-1:0]  rd_cnt;
   logic              first;
   logic [ADDR_W-1:0] h_paddr;
   logic [SH_W-1:0]   h_shift;

   xrf_slot_table #(
      .NSLOT(NSLOT), .MAXMEM(MAXMEM), .ADDR_W(ADDR_W), .KEY_W(KEY_W), .ID_W(ID_W),
      .SLOT_W(SLOT_W), .MEM_W(MEM_W), .CNT_W(CNT_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_valid (ins_valid),
      .ins_slot  (ins_slot),
      .ins_key   (ins_vpage),
      .ins_cnt   (ins_count),
      .ins_va    (ins_vaddrs),
      .ins_id    (ins_ids),
      .look_key  (tr_vaddr[ADDR_W-1:PG_SHIFT]),
      .look_hit  (look_hit),
      .look_slot (look_slot),
      .ret_en    (ret_en),
      .ret_slot  (ret_slot),
      .rd_slot   (cur_slot),
      .rd_mem    (cur_mem),
      .rd_va     (rd_va),
      .rd_id     (rsp_id),
      .rd_cnt    (rd_cnt),
      .busy      (slot_busy)
   );

   xrf_seq #(
      .ADDR_W(ADDR_W), .SH_W(SH_W), .LVL_W(LVL_W),
      .SLOT_W(SLOT_W), .MEM_W(MEM_W), .CNT_W(CNT_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .tr_valid     (tr_valid),
      .tr_ready     (tr_ready),
      .tr_paddr     (tr_paddr),
      .tr_pg_shift  (tr_pg_shift),
      .tr_uncache   (tr_uncache),
      .tr_hit_lvl   (tr_hit_lvl),
      .tr_ent_vbase (tr_ent_vbase),
      .tr_ent_pbase (tr_ent_pbase),
      .look_hit     (look_hit),
      .look_slot    (look_slot),
      .rd_cnt       (rd_cnt),
      .rsp_ready    (rsp_ready),
      .rsp_valid    (rsp_valid),
      .cur_slot     (cur_slot),
      .cur_mem      (cur_mem),
      .first        (first),
      .h_paddr      (h_paddr),
      .h_shift      (h_shift),
      .h_unc        (rsp_uncache),
      .h_lvl        (rsp_hit_lvl),
      .h_vbase      (rsp_ent_vbase),
      .h_pbase      (rsp_ent_pbase),
      .ret_en       (ret_en),
      .ret_slot     (ret_slot),
      .tr_err       (tr_err)
   );

   xrf_pa_merge #(
      .ADDR_W(ADDR_W), .SH_W(SH_W)
   ) u_merge (
      .base_pa   (h_paddr),
      .shift     (h_shift),
      .member_va (rd_va),
      .first     (first),
      .pa        (rsp_paddr)
   );

endmodule

// File: tb/xlat_rsp_fanout_test.sv
`timescale 1ns/1ps
module xlat_rsp_fanout_test;

   localparam int NS = 4;
   localparam int NM = 4;
   localparam int AW = 32;
   localparam int PS = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ins_valid = 1'b0;
   logic [1:0]    ins_slot = '0;
   logic [19:0]   ins_vpage = '0;
   logic [2:0]    ins_count = '0;
   logic [127:0]  ins_vaddrs = '0;
   logic [11:0]   ins_ids = '0;
   logic [3:0]    slot_busy;
   logic          tr_valid = 1'b0;
   logic          tr_ready;
   logic [31:0]   tr_vaddr = '0, tr_paddr = '0, tr_ent_vbase = '0, tr_ent_pbase = '0;
   logic [4:0]    tr_pg_shift = 5'd12;
   logic          tr_uncache = 1'b0;
   logic [1:0]    tr_hit_lvl = '0;
   logic          tr_err, rsp_valid;
   logic          rsp_ready = 1'b1;
   logic [2:0]    rsp_id;
   logic [31:0]   rsp_paddr, rsp_ent_vbase, rsp_ent_pbase;
   logic          rsp_uncache;
   logic [1:0]    rsp_hit_lvl;

   xlat_rsp_fanout uut (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_slot(ins_slot), .ins_vpage(ins_vpage), .ins_count(ins_count),
      .ins_vaddrs(ins_vaddrs), .ins_ids(ins_ids), .slot_busy(slot_busy),
      .tr_valid(tr_valid), .tr_ready(tr_ready), .tr_vaddr(tr_vaddr), .tr_paddr(tr_paddr),
      .tr_pg_shift(tr_pg_shift), .tr_uncache(tr_uncache), .tr_hit_lvl(tr_hit_lvl),
      .tr_ent_vbase(tr_ent_vbase), .tr_ent_pbase(tr_ent_pbase), .tr_err(tr_err),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rsp_paddr(rsp_paddr),
      .rsp_uncache(rsp_uncache), .rsp_hit_lvl(rsp_hit_lvl),
      .rsp_ent_vbase(rsp_ent_vbase), .rsp_ent_pbase(rsp_ent_pbase)
   );

   always #4 clk = ~clk;

   int total = 0;
   int fails = 0;
   bit stall_mode = 1'b0;
   bit compare_on = 1'b0;

   // reference model state
   bit [3:0]    m_v;
   logic [19:0] m_key [NS];
   int          m_cnt [NS];
   logic [31:0] m_va  [NS][NM];
   logic [2:0]  m_id  [NS][NM];
   bit          m_busy, m_err;
   int          m_slot, m_idx;
   logic [31:0] t_pa, t_vb, t_pb;
   int          t_sh;
   logic        t_unc;
   logic [1:0]  t_lvl;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   // model advances on every rising edge from the same inputs the design sees
   always @(posedge clk) begin
      if (!rst_n) begin
         m_v = '0; m_busy = 0; m_err = 0; m_slot = 0; m_idx = 0;
      end else begin
         bit acc, hit, take;
         int hs;
         acc = tr_valid && !m_busy;
         hit = 0; hs = 0;
         for (int s = NS - 1; s >= 0; s--)
            if (m_v[s] && m_key[s] == tr_vaddr[31:PS]) begin hit = 1; hs = s; end
         take = ins_valid && ins_count >= 1 && ins_count <= NM && !m_v[ins_slot];
         m_err = acc && !hit;
         if (m_busy && rsp_ready) begin
            if (m_idx == m_cnt[m_slot] - 1) begin
               m_v[m_slot] = 1'b0; m_busy = 0;
            end else m_idx++;
         end
         if (take) begin
            m_v[ins_slot] = 1'b1;
            m_key[ins_slot] = ins_vpage;
            m_cnt[ins_slot] = int'(ins_count);
            for (int m = 0; m < NM; m++) begin
               m_va[ins_slot][m] = ins_vaddrs[m*AW +: AW];
               m_id[ins_slot][m] = ins_ids[m*3 +: 3];
            end
         end
         if (acc && hit) begin
            m_busy = 1; m_slot = hs; m_idx = 0;
            t_pa = tr_paddr; t_sh = int'(tr_pg_shift); t_unc = tr_uncache;
            t_lvl = tr_hit_lvl; t_vb = tr_ent_vbase; t_pb = tr_ent_pbase;
         end
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n && compare_on) begin
         chk(tr_ready === !m_busy, "R3", "tr_ready", longint'(tr_ready), longint'(!m_busy));
         chk(rsp_valid === m_busy, "R4", "rsp_valid", longint'(rsp_valid), longint'(m_busy));
         chk(tr_err === m_err, "R10", "tr_err", longint'(tr_err), longint'(m_err));
         chk(slot_busy === m_v, "R1 R2 R9", "slot_busy", longint'(slot_busy), longint'(m_v));
         if (m_busy) begin
            longint unsigned pg, exp_pa;
            pg = longint'(64'd1) << t_sh;
            if (m_idx == 0) exp_pa = longint'(t_pa);
            else exp_pa = (longint'(t_pa) / pg) * pg + (longint'(m_va[m_slot][m_idx]) % pg);
            chk(rsp_id === m_id[m_slot][m_idx], "R2 R8", "rsp_id",
                longint'(rsp_id), longint'(m_id[m_slot][m_idx]));
            chk(longint'(rsp_paddr) == exp_pa, (m_idx == 0) ? "R5" : "R6", "rsp_paddr",
                longint'(rsp_paddr), exp_pa);
            chk({rsp_uncache, rsp_hit_lvl, rsp_ent_vbase, rsp_ent_pbase} ===
                {t_unc, t_lvl, t_vb, t_pb}, "R7", "attributes",
                longint'({rsp_uncache, rsp_hit_lvl, rsp_ent_vbase}),
                longint'({t_unc, t_lvl, t_vb}));
         end
      end
   end

   always @(negedge clk) begin
      if (stall_mode) rsp_ready <= ($urandom % 3) != 0;
      else rsp_ready <= 1'b1;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   task automatic install(int slot, logic [19:0] key, int cnt, logic [47:0] offs, logic [11:0] ids);
      @(negedge clk);
      ins_valid = 1'b1; ins_slot = 2'(slot); ins_vpage = key; ins_count = 3'(cnt);
      for (int m = 0; m < NM; m++) ins_vaddrs[m*AW +: AW] = {key, offs[m*12 +: 12]};
      ins_ids = ids;
      @(negedge clk);
      ins_valid = 1'b0;
   endtask

   task automatic send(logic [31:0] va, logic [31:0] pa, int sh, bit unc, logic [1:0] lvl);
      @(negedge clk);
      tr_valid = 1'b1; tr_vaddr = va; tr_paddr = pa; tr_pg_shift = 5'(sh);
      tr_uncache = unc; tr_hit_lvl = lvl; tr_ent_vbase = va ^ 32'h0f0f_0000; tr_ent_pbase = pa ^ 32'h00f0_f000;
      while (!tr_ready) @(negedge clk);
      @(negedge clk);
      tr_valid = 1'b0;
   endtask

   task automatic drain();
      stall_mode = 1'b0;
      repeat (2) @(negedge clk);
      while (m_busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(tr_ready === 1'b1, "R11", "tr_ready", longint'(tr_ready), 1);
      chk(rsp_valid === 1'b0, "R11", "rsp_valid", longint'(rsp_valid), 0);
      chk(tr_err === 1'b0, "R11", "tr_err", longint'(tr_err), 0);
      chk(slot_busy === 4'b0, "R11", "slot_busy", longint'(slot_busy), 0);
      rst_n = 1'b1;
      compare_on = 1'b1;

      // R5/R6: leading member raw, later members rebuilt on a 4 KiB page
      install(0, 20'h12345, 4, {12'hfff, 12'h004, 12'h7f8, 12'h010}, {3'd1, 3'd7, 3'd2, 3'd5});
      send({20'h12345, 12'h010}, 32'h8765_4abc, 12, 1'b0, 2'd1);
      drain();

      // R7 uncacheable, 64 KiB page, stalls on the response side
      stall_mode = 1'b1;
      install(1, 20'h00aa7, 3, {12'h0, 12'h123, 12'habc, 12'h456}, {3'd0, 3'd3, 3'd6, 3'd4});
      send({20'h00aa7, 12'h456}, 32'h5a5a_5a5a, 16, 1'b1, 2'd3);
      drain();

      // R10 miss, then R1 install into busy slot and bad count are ignored
      send(32'hdead_b000, 32'h1111_1111, 12, 1'b0, 2'd0);
      install(2, 20'h00111, 2, 48'h111_222_333_444, 12'o1234);
      install(2, 20'h00999, 4, 48'h999_888_777_666, 12'o7777);
      install(3, 20'h00222, 0, 48'h0, 12'o0);
      install(3, 20'h00111, 1, 48'h0_0_0_abc, 12'o0006);
      // R2 duplicate key: slot 2 served first, then slot 3
      send({20'h00111, 12'h444}, 32'hc000_0444, 21, 1'b0, 2'd2);
      send({20'h00111, 12'habc}, 32'hc000_0abc, 12, 1'b1, 2'd1);
      drain();

      // mixed traffic
      for (int it = 0; it < 80; it++) begin
         logic [19:0] k;
         stall_mode = ($urandom % 2) == 1;
         k = 20'h00040 + 20'($urandom % 5);
         if ($urandom % 2)
            install(int'($urandom % 4), k, int'($urandom % 5),
                    {16'($urandom), 32'($urandom)}, 12'($urandom));
         k = 20'h00040 + 20'($urandom % 5);
         send({k, 12'($urandom)}, 32'($urandom), 12 + int'($urandom % 12),
              1'($urandom), 2'($urandom));
      end
      drain();
      finish_run();
   end

endmodule